// File: doc/BRIEF.md
# Per-Core Compare Timer with Virtual Count Offset

This block gives one processor core two compare timers that run off a free-running 64-bit system count. The physical channel compares against the system count as it arrives. The virtual channel compares against a virtual count, which is the system count minus a 64-bit offset register. Each channel holds a 64-bit absolute compare value and exposes it a second way, as a signed 32-bit relative value. Writing the relative value sets the compare value to the current count plus that value. Reading it returns the time left before the compare value is reached.

Each channel has an enable bit, a mask bit and a read-only status bit. Each drives its own level interrupt to the local core. The interrupt is high while the channel is enabled, unmasked and its compare value is at or below its count. It stays high until software masks it, disables the channel or moves the compare value past the count. Registers are reached through a plain single-cycle read/write port. Reads are combinational on the address. Writes take effect at the clock edge.

Each channel runs a four-state machine. OFF means disabled. WAIT means enabled with the condition not yet met. FIRE means enabled, condition met and unmasked, with the interrupt driven. HOLD means enabled, condition met and masked. On every clock the machine moves to the state chosen by the current enable, mask and condition values:
- any state → OFF when enable is 0
- → WAIT when enabled and not met
- → FIRE when enabled, met and unmasked
- → HOLD when enabled, met and masked

Top module: `core_timer`

## Requirements
- R1: Address 0 reads the FREQ_HZ parameter, zero-extended. Address 1 reads the system count. Writes to addresses 0, 1 and 3 change nothing. Addresses 10 to 15 read as zero.
- R2: Each channel's compare value is read and written as 64 bits, at address 4 (physical) or 7 (virtual). Its condition is met when compare ≤ count, using an unsigned comparison.
- R3: A write to a channel's relative-value address (5 physical, 8 virtual) sets the compare value to that channel's current count plus wdata[31:0] sign-extended to 64 bits. A negative value therefore meets the condition at once.
- R4: Reading the relative-value address returns the low 32 bits of (compare − channel count).
- R5: The control register sits at address 6 (physical) or 9 (virtual). Bit 0 is enable and bit 1 is mask; both are read/write. Bit 2 is a read-only status bit equal to enable AND condition met, so it reads 0 while the channel is disabled. All other bits read 0.
- R6: A channel's interrupt is registered. After each clock edge it equals enable AND NOT mask AND met, evaluated from the register values and count that were present before that edge.
- R7: An asserted interrupt stays high until the mask bit is set, the enable bit is cleared, or a compare or relative-value write makes the condition false. It falls one clock after that register update.
- R8: Address 2 holds the 64-bit read/write offset. Address 3 reads the virtual count, which is the system count minus the offset.
- R9: The virtual channel compares against the virtual count, and its relative value is taken against the virtual count. Its interrupt is independent of the physical channel.
- R10: After reset, both interrupts are low and every compare, control and offset register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_count | input | 64 | Free-running system count |
| bus_we | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr (combinational) |
| irq_phys | output | 1 | Physical channel interrupt level |
| irq_virt | output | 1 | Virtual channel interrupt level |

## Verification
Suppose a channel's state register disagrees with its enable, mask and condition. The wrong value then shows on that channel's interrupt one clock after the inputs that caused it, so a per-cycle comparison of both interrupts against a bench model catches it within one cycle. A corrupted compare or offset register shows up the next time the compare, relative-value, status or virtual-count address is read. It also shows as an early or late interrupt edge at the point where the count crosses the compare value. Directed cases stress the exact crossing, the unsigned comparison, negative relative values and each of the three ways to drop the interrupt. Random traffic mixes these with offset changes.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_FIRE = 2'd2,
        ST_HOLD = 2'd3
    } ch_state_t;

    localparam int unsigned A_FREQ    = 0;
    localparam int unsigned A_PCOUNT  = 1;
    localparam int unsigned A_VOFF    = 2;
    localparam int unsigned A_VCOUNT  = 3;
    localparam int unsigned A_CH_BASE = 4;
    localparam int unsigned CH_STRIDE = 3;
    localparam int unsigned OFS_CMP   = 0;
    localparam int unsigned OFS_TVAL  = 1;
    localparam int unsigned OFS_CTRL  = 2;

    localparam int unsigned BIT_EN    = 0;
    localparam int unsigned BIT_MASK  = 1;
    localparam int unsigned BIT_STAT  = 2;

endpackage

// File: rtl/ctmr_vcount.sv
module ctmr_vcount #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_off,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] pcount,
    output logic [CNT_W-1:0] voff_o,
    output logic [CNT_W-1:0] vcount_o
);

    logic [CNT_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (wr_off) begin
            off_q <= wdata;
        end
    end

    assign voff_o   = off_q;
    assign vcount_o = pcount - off_q;

    // R8: offset only moves on its own write
    p_off_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_off |=> $stable(off_q));

endmodule

// File: rtl/ctmr_channel.sv
module ctmr_channel
    import ctmr_pkg::*;
#(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned TV_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             wr_cmp,
    input  logic             wr_tval,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cmp_o,
    output logic [TV_W-1:0]  tval_o,
    output logic             en_o,
    output logic             mask_o,
    output logic             status_o,
    output logic             irq_o
);

    localparam int unsigned EXT_W = CNT_W - TV_W;

    logic [CNT_W-1:0] cmp_q;
    logic             en_q;
    logic             mask_q;
    logic             met;
    logic [CNT_W-1:0] tval_sext;
    ch_state_t        state_q;
    ch_state_t        state_d;

    assign met       = (cmp_q <= count);
    assign tval_sext = {{EXT_W{wdata[TV_W-1]}}, wdata[TV_W-1:0]};

    // register file of the channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            en_q   <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (wr_cmp) begin
                cmp_q <= wdata;
            end else if (wr_tval) begin
                cmp_q <= count + tval_sext;
            end
            if (wr_ctrl) begin
                en_q   <= wdata[BIT_EN];
                mask_q <= wdata[BIT_MASK];
            end
        end
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF, ST_WAIT, ST_FIRE, ST_HOLD: begin
                if (!en_q) begin
                    state_d = ST_OFF;
                end else if (!met) begin
                    state_d = ST_WAIT;
                end else if (mask_q) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = ST_FIRE;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            ST_FIRE:                   irq_o = 1'b1;
            ST_OFF, ST_WAIT, ST_HOLD:  irq_o = 1'b0;
            default:                   irq_o = 1'b0;
        endcase
    end

    assign cmp_o    = cmp_q;
    assign tval_o   = TV_W'(cmp_q - count);
    assign en_o     = en_q;
    assign mask_o   = mask_q;
    assign status_o = en_q & met;

    // R6: interrupt implies the channel was enabled one cycle earlier
    p_irq_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(en_q));

    // R6: interrupt implies the condition held one cycle earlier
    p_irq_met_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(cmp_q <= count));

    // R7: a set mask silences the interrupt on the next cycle
    p_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |=> !irq_o);

    // R3: relative write loads count plus the sign-extended value
    p_tval_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tval && !wr_cmp) |=> (cmp_q == $past(count) + $past(tval_sext)));

endmodule

// File: rtl/core_timer.sv
module core_timer
    import ctmr_pkg::*;
#(
    parameter int unsigned CNT_W   = 64,
    parameter int unsigned TV_W    = 32,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned FREQ_HZ = 24_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_count,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_phys,
    output logic              irq_virt
);

    localparam int unsigned NUM_CH = 2;

    logic [CNT_W-1:0] voff;
    logic [CNT_W-1:0] vcount;
    logic [CNT_W-1:0] ch_count [NUM_CH];
    logic [CNT_W-1:0] ch_cmp   [NUM_CH];
    logic [TV_W-1:0]  ch_tval  [NUM_CH];
    logic             ch_en    [NUM_CH];
    logic             ch_mask  [NUM_CH];
    logic             ch_stat  [NUM_CH];
    logic             ch_irq   [NUM_CH];

    ctmr_vcount #(.CNT_W(CNT_W)) u_vcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_off   (bus_we && (bus_addr == ADDR_W'(A_VOFF))),
        .wdata    (bus_wdata),
        .pcount   (sys_count),
        .voff_o   (voff),
        .vcount_o (vcount)
    );

    assign ch_count[0] = sys_count;
    assign ch_count[1] = vcount;

    for (genvar g = 0; g < NUM_CH; g++) begin : gen_ch
        localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(A_CH_BASE + CH_STRIDE * g + OFS_CMP);
        localparam logic [ADDR_W-1:0] A_TVAL = ADDR_W'(A_CH_BASE + CH_STRIDE * g + OFS_TVAL);
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(A_CH_BASE + CH_STRIDE * g + OFS_CTRL);

        ctmr_channel #(.CNT_W(CNT_W), .TV_W(TV_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .count    (ch_count[g]),
            .wr_cmp   (bus_we && (bus_addr == A_CMP)),
            .wr_tval  (bus_we && (bus_addr == A_TVAL)),
            .wr_ctrl  (bus_we && (bus_addr == A_CTRL)),
            .wdata    (bus_wdata),
            .cmp_o    (ch_cmp[g]),
            .tval_o   (ch_tval[g]),
            .en_o     (ch_en[g]),
            .mask_o   (ch_mask[g]),
            .status_o (ch_stat[g]),
            .irq_o    (ch_irq[g])
        );
    end

    assign irq_phys = ch_irq[0];
    assign irq_virt = ch_irq[1];

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_FREQ))   bus_rdata = CNT_W'(FREQ_HZ);
        if (bus_addr == ADDR_W'(A_PCOUNT)) bus_rdata = sys_count;
        if (bus_addr == ADDR_W'(A_VOFF))   bus_rdata = voff;
        if (bus_addr == ADDR_W'(A_VCOUNT)) bus_rdata = vcount;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (bus_addr == ADDR_W'(A_CH_BASE + CH_STRIDE * ch + OFS_CMP))
                bus_rdata = ch_cmp[ch];
            if (bus_addr == ADDR_W'(A_CH_BASE + CH_STRIDE * ch + OFS_TVAL))
                bus_rdata = CNT_W'(ch_tval[ch]);
            if (bus_addr == ADDR_W'(A_CH_BASE + CH_STRIDE * ch + OFS_CTRL))
                bus_rdata = CNT_W'({ch_stat[ch], ch_mask[ch], ch_en[ch]});
        end
    end

    // R10: both interrupts are low in the first cycle after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!irq_phys && !irq_virt));

endmodule

// File: tb/core_timer_bench.sv
module core_timer_bench;

    localparam int unsigned FREQ = 24_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = 64'd1000;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [63:0] bus_wdata = 64'd0;
    logic [63:0] bus_rdata;
    logic        irq_phys;
    logic        irq_virt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [63:0] m_cmp [2];
    logic        m_en  [2];
    logic        m_mask[2];
    logic [63:0] m_off;
    logic        e_irq [2];

    always #2.5 clk = ~clk;

    core_timer #(.FREQ_HZ(FREQ)) u_core_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_count (cnt),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_phys  (irq_phys),
        .irq_virt  (irq_virt)
    );

    function automatic logic [63:0] f_chcnt(input int ch);
        return (ch == 0) ? cnt : cnt - m_off;
    endfunction

    function automatic logic [63:0] f_read(input logic [3:0] a);
        int ch;
        if (a == 4'd0) return 64'(FREQ);
        if (a == 4'd1) return cnt;
        if (a == 4'd2) return m_off;
        if (a == 4'd3) return cnt - m_off;
        if (a >= 4'd10) return 64'd0;
        ch = (int'(a) - 4) / 3;
        case ((int'(a) - 4) % 3)
            0: return m_cmp[ch];
            1: return {32'd0, 32'(m_cmp[ch] - f_chcnt(ch))};
            default: return {61'd0, m_en[ch] & (m_cmp[ch] <= f_chcnt(ch)), m_mask[ch], m_en[ch]};
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h", req, got, exp);
        end
    endtask

    // model of one clock edge, using the inputs held across it
    task automatic model_edge();
        for (int ch = 0; ch < 2; ch++) begin
            e_irq[ch] = m_en[ch] & ~m_mask[ch] & (m_cmp[ch] <= f_chcnt(ch));
        end
        if (bus_we) begin
            logic [63:0] c0 = f_chcnt(0);
            logic [63:0] c1 = f_chcnt(1);
            if (bus_addr == 4'd2) m_off = bus_wdata;
            for (int ch = 0; ch < 2; ch++) begin
                logic [63:0] c = (ch == 0) ? c0 : c1;
                if (int'(bus_addr) == 4 + 3 * ch) m_cmp[ch] = bus_wdata;
                if (int'(bus_addr) == 5 + 3 * ch)
                    m_cmp[ch] = c + {{32{bus_wdata[31]}}, bus_wdata[31:0]};
                if (int'(bus_addr) == 6 + 3 * ch) begin
                    m_en[ch]   = bus_wdata[0];
                    m_mask[ch] = bus_wdata[1];
                end
            end
        end
    endtask

    // one clock: drive, edge, model, check both interrupts (R6)
    task automatic cycle(input logic we, input logic [3:0] a, input logic [63:0] d, input int inc);
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        bus_we = 1'b0;
        cnt = cnt + 64'(inc);
        check("R6 irq_phys", {63'd0, irq_phys}, {63'd0, e_irq[0]});
        check("R6 irq_virt", {63'd0, irq_virt}, {63'd0, e_irq[1]});
    endtask

    task automatic rd(input string req, input logic [3:0] a);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        check(req, bus_rdata, f_read(a));
    endtask

    task automatic idle(input int n, input int inc);
        for (int i = 0; i < n; i++) cycle(1'b0, 4'd0, 64'd0, inc);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int seed_dummy;
        seed_dummy = $urandom(32'd24681);
        for (int ch = 0; ch < 2; ch++) begin
            m_cmp[ch] = '0; m_en[ch] = 1'b0; m_mask[ch] = 1'b0; e_irq[ch] = 1'b0;
        end
        m_off = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10 irq_phys", {63'd0, irq_phys}, 64'd0);
        check("R10 irq_virt", {63'd0, irq_virt}, 64'd0);
        for (int a = 4; a < 10; a++) begin
            if ((a - 4) % 3 != 1) rd("R10 reset regs", 4'(a));
        end
        rd("R10 offset", 4'd2);

        // R1 frequency, count, read-only, unmapped
        rd("R1 freq", 4'd0);
        rd("R1 count", 4'd1);
        cycle(1'b1, 4'd0, 64'hDEAD, 1);
        cycle(1'b1, 4'd1, 64'hBEEF, 1);
        cycle(1'b1, 4'd3, 64'hCAFE, 1);
        rd("R1 freq after write", 4'd0);
        rd("R1 count after write", 4'd1);
        rd("R1 vcount after write", 4'd3);
        rd("R1 unmapped", 4'd12);

        // R2 exact crossing on the physical channel
        cycle(1'b1, 4'd4, cnt + 64'd6, 1);
        cycle(1'b1, 4'd6, 64'd1, 1);
        rd("R2 cmp readback", 4'd4);
        idle(8, 1);
        check("R2 fired after crossing", {63'd0, irq_phys}, 64'd1);

        // R2 unsigned compare: huge compare never met
        cycle(1'b1, 4'd4, 64'hFFFF_FFFF_FFFF_0000, 1);
        idle(2, 1);
        rd("R2 unsigned status", 4'd6);
        check("R2 unsigned no irq", {63'd0, irq_phys}, 64'd0);

        // R3/R4 positive relative value
        cycle(1'b1, 4'd5, 64'd50, 1);
        rd("R3 cmp from tval", 4'd4);
        idle(5, 3);
        rd("R4 tval decreases", 4'd5);

        // R3 negative relative value fires at once
        cycle(1'b1, 4'd5, 64'h0000_0000_FFFF_FFF0, 1);
        rd("R3 negative cmp", 4'd4);
        rd("R5 status met", 4'd6);
        rd("R4 tval negative", 4'd5);
        idle(1, 1);
        check("R3 immediate irq", {63'd0, irq_phys}, 64'd1);

        // R7 mask drops the level, unmask restores it
        cycle(1'b1, 4'd6, 64'd3, 1);
        idle(1, 1);
        check("R7 mask drops irq", {63'd0, irq_phys}, 64'd0);
        rd("R5 status while masked", 4'd6);
        cycle(1'b1, 4'd6, 64'd1, 1);
        idle(1, 1);
        check("R7 unmask restores", {63'd0, irq_phys}, 64'd1);

        // R7 rewrite compare into the future drops it
        cycle(1'b1, 4'd5, 64'd1000, 1);
        idle(1, 1);
        check("R7 rewrite drops irq", {63'd0, irq_phys}, 64'd0);

        // R5/R7 disable: status reads 0 though met
        cycle(1'b1, 4'd4, 64'd0, 1);
        idle(2, 1);
        check("R7 refired", {63'd0, irq_phys}, 64'd1);
        cycle(1'b1, 4'd6, 64'd0, 1);
        idle(1, 1);
        check("R7 disable drops irq", {63'd0, irq_phys}, 64'd0);
        rd("R5 status disabled", 4'd6);

        // R8/R9 virtual channel with an offset
        cycle(1'b1, 4'd2, 64'd900, 1);
        rd("R8 offset", 4'd2);
        rd("R8 vcount", 4'd3);
        cycle(1'b1, 4'd8, 64'd4, 1);
        rd("R9 vcmp from vcount", 4'd7);
        cycle(1'b1, 4'd9, 64'd1, 1);
        idle(6, 1);
        check("R9 virt fired", {63'd0, irq_virt}, 64'd1);
        check("R9 phys independent", {63'd0, irq_phys}, 64'd0);
        rd("R9 vtval", 4'd8);

        // random traffic
        for (int it = 0; it < 600; it++) begin
            int ch = int'($urandom % 2);
            int op = int'($urandom % 8);
            int inc = int'($urandom % 3);
            logic [63:0] c = f_chcnt(ch);
            case (op)
                0: cycle(1'b1, 4'(4 + 3 * ch), c + 64'($urandom % 40) - 64'd20, inc);
                1: cycle(1'b1, 4'(5 + 3 * ch), {32'd0, 32'($urandom % 64) - 32'd32}, inc);
                2: cycle(1'b1, 4'(6 + 3 * ch), 64'($urandom % 4), inc);
                3: cycle(1'b1, 4'd2, 64'($urandom % 16), inc);
                default: cycle(1'b0, 4'd0, 64'd0, inc);
            endcase
            rd("R2-R9 random read", 4'($urandom % 16));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule